// File: doc/BRIEF.md
# Data Cache Maintenance Sequencer

This block carries out maintenance operations on a first-level data cache. A requester asks for a flush, an invalidate or a flush-and-invalidate. The request covers either the whole cache or a byte range, given as a start address and an end address one past the last byte. A whole-cache request becomes a single entire-cache command. A range request is aligned down to a line boundary, widened by the offset that was dropped, and walked line by line. Each command goes to the cache over a valid/ready handshake.

A small control register holds a cache-disable bit and an invalidate-mode bit. It also shows a read-only write-back-in-progress flag that mirrors the cache's status input. The invalidate-mode bit tells the cache whether an invalidate command discards a line or writes it back first. The sequencer sets or clears this bit when it accepts an operation. When the operation includes a flush, completion waits until the write-back status has cleared. A one-cycle `done` pulse marks the end of every accepted request.

The cache arrays, tag lookup and write-back datapath sit outside this block.

Top module: `dcache_maint_seq`

## Requirements
- R1: The control register resets to all zeros. Bit 0 is cache-disable and bit 6 is invalidate-mode; both are written by `ctl_wr_data` when `ctl_wr_en` is high. Bit 8 is read-only and always equals `wb_busy`. Every other bit reads zero.
- R2: `req_op` bit 0 means invalidate and bit 1 means flush (01 invalidate, 10 flush, 11 flush-and-invalidate). Accepting a 01 operation clears invalidate-mode; accepting 10 or 11 sets it. When a register write falls in the same cycle as that acceptance, the operation's value wins for bit 6. While an operation is in progress, register writes leave bit 6 unchanged.
- R3: `cmd_kind` encodes 0 line-invalidate, 1 line-flush, 2 whole-invalidate and 3 whole-flush. An operation whose `req_op` bit 0 is set uses the invalidate kinds; a flush-only operation uses the flush kinds.
- R4: For a range, the first command address is `req_start` rounded down to a line boundary. The number of line commands is (`req_end` - `req_start` + start offset within its line) divided by the line size, rounded up.
- R5: The line size is 16 << `cfg_line_len`, taken when the request is accepted. Consecutive line commands step the address by one line size.
- R6: A request accepted while the disable bit is set issues no command and pulses `done` in the cycle after acceptance. The disable value used is the one held before any write in the acceptance cycle.
- R7: A range request with `req_start` >= `req_end`, or any request with `req_op` = 00, issues no command and pulses `done` in the cycle after acceptance.
- R8: For a flush or flush-and-invalidate, `done` pulses in the cycle after the first cycle, counted from the cycle following the last command acceptance, in which `wb_busy` is low.
- R9: For a pure invalidate, `done` pulses in the cycle after the last command is accepted, whatever `wb_busy` does.
- R10: A whole-cache request issues exactly one command, with `cmd_addr` zero.
- R11: `done` is a single-cycle pulse. `req_ready` is low from acceptance until `done`, so requests during that time are refused. A pending command keeps its kind and address until `cmd_ready`.

Note: `cmd_ready` sampled while the sequencer is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Bit 0 invalidate, bit 1 flush |
| req_whole | input | 1 | 1: whole cache, 0: address range |
| req_start | input | AW | First byte of range |
| req_end | input | AW | One past last byte of range |
| cfg_line_len | input | LEN_W | Line length code, line = 16 << code bytes |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | CW | Control register write value |
| ctl_rd_data | output | CW | Control register read value |
| cmd_valid | output | 1 | Cache command present |
| cmd_ready | input | 1 | Cache accepts command |
| cmd_kind | output | 2 | Command kind (see R3) |
| cmd_addr | output | AW | Line address for line commands, zero for whole |
| wb_busy | input | 1 | Cache write-back in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can land in the same cycle: a software write to the control register and the acceptance of a request. Both act on the invalidate-mode bit, and the write's disable bit competes with the acceptance decision. The bench drives a write of invalidate-mode = 1 in the same cycle as a plain invalidate request, and expects bit 6 to read 0 afterwards. It also drives a write that sets disable in the same cycle as a flush request. That flush must still run in full, because acceptance uses the old disable value, and the next request must then finish with no commands.

// File: rtl/dcm_pkg.sv
// Package: shared constants and types for the data cache maintenance sequencer.
// Assumes: command kind encoding is {whole, flush_only}.
package dcm_pkg;

    localparam logic [1:0] CK_LINE_INV   = 2'd0;
    localparam logic [1:0] CK_LINE_FLUSH = 2'd1;
    localparam logic [1:0] CK_ALL_INV    = 2'd2;
    localparam logic [1:0] CK_ALL_FLUSH  = 2'd3;

    localparam int CTL_DIS_BIT   = 0;
    localparam int CTL_IMODE_BIT = 6;
    localparam int CTL_WBST_BIT  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dcm_ctl_reg.sv
// Module: control register holding the disable and invalidate-mode bits.
// The sequencer owns the mode bit at acceptance; software cannot change
// it while an operation runs. The write-back status bit mirrors wb_busy.
// Assumes: CW > CTL_WBST_BIT.
module dcm_ctl_reg
    import dcm_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          seq_busy,
    input  logic          mode_set,
    input  logic          mode_clr,
    input  logic          wb_busy,
    output logic [CW-1:0] rd_data,
    output logic          dis_o,
    output logic          imode_o
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // Disable bit: software-written at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) dis_o <= 1'b0;
        else if (wr_en) dis_o <= wr_data[CTL_DIS_BIT];
    end

    // Mode bit: sequencer update beats software; software locked out while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                  imode_o <= 1'b0;
        else if (mode_set)           imode_o <= 1'b1;
        else if (mode_clr)           imode_o <= 1'b0;
        else if (wr_en && !seq_busy) imode_o <= wr_data[CTL_IMODE_BIT];
    end

    // Read view: fixed bit positions, others zero.
    always_comb begin
        rd_data                = '0;
        rd_data[CTL_DIS_BIT]   = dis_o;
        rd_data[CTL_IMODE_BIT] = imode_o;
        rd_data[CTL_WBST_BIT]  = wb_busy;
    end

    // R2: mode bit held steady while an operation runs
    p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> (imode_o == $past(imode_o)));

    // R2: acceptance update wins over a same-cycle write
    p_mode_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr |=> !imode_o);

endmodule

// File: rtl/dcm_range_calc.sv
// Module: turns a byte range and line-length code into an aligned base,
// a line count and a line step. Purely combinational.
// Assumes: 16 << len fits in AW bits for the codes in use.
module dcm_range_calc #(
    parameter int AW    = 32,
    parameter int LEN_W = 4,
    parameter int CNT_W = AW + 2
) (
    input  logic [AW-1:0]    start_i,
    input  logic [AW-1:0]    end_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [AW-1:0]    base_o,
    output logic [AW-1:0]    step_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o
);

    localparam int SH_W = LEN_W + 1;

    logic [AW-1:0]    mask;
    logic [AW-1:0]    off;
    logic [AW-1:0]    sz;
    logic [CNT_W-1:0] tot;
    logic [SH_W-1:0]  sh;

    // Line geometry and rounded-up line count.
    always_comb begin
        step_o  = AW'(16) << len_i;
        mask    = step_o - AW'(1);
        off     = start_i & mask;
        base_o  = start_i & ~mask;
        sz      = end_i - start_i;
        sh      = SH_W'(len_i) + SH_W'(4);
        tot     = CNT_W'(sz) + CNT_W'(off);
        count_o = (tot + CNT_W'(mask)) >> sh;
        empty_o = !(start_i < end_i);
    end

endmodule

// File: rtl/dcm_seq.sv
// Module: maintenance sequencer FSM. Accepts a request, issues one
// entire-cache command or a walk of per-line commands, then waits for
// write-back to finish when a flush is involved, and pulses done.
// Assumes: wb_busy rises no later than one cycle after a flush command
// is accepted.
module dcm_seq
    import dcm_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = AW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_whole,
    input  logic [AW-1:0]    base_i,
    input  logic [AW-1:0]    step_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             empty_i,
    input  logic             disabled_i,
    input  logic             cmd_ready,
    input  logic             wb_busy,
    output logic             req_ready,
    output logic             mode_set,
    output logic             mode_clr,
    output logic             cmd_valid,
    output logic [1:0]       cmd_kind,
    output logic [AW-1:0]    cmd_addr,
    output logic             done
);

    seq_state_e       state;
    logic [CNT_W-1:0] left_q;
    logic [AW-1:0]    step_q;
    logic [1:0]       op_q;
    logic             whole_q;
    logic             fire;
    logic             skip;

    // Acceptance and no-work decision.
    always_comb begin
        req_ready = (state == ST_IDLE);
        fire      = req_valid && req_ready;
        skip      = disabled_i || (req_op == 2'b00) || (!req_whole && empty_i);
        mode_set  = fire && !skip && req_op[1];
        mode_clr  = fire && !skip && !req_op[1];
        cmd_valid = (state == ST_ISSUE);
        cmd_kind  = {whole_q, !op_q[0]};
    end

    // Sequencer state, walk counters and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            left_q   <= '0;
            step_q   <= '0;
            op_q     <= 2'b00;
            whole_q  <= 1'b0;
            cmd_addr <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fire) begin
                        if (skip) begin
                            done <= 1'b1;
                        end else begin
                            op_q     <= req_op;
                            whole_q  <= req_whole;
                            step_q   <= step_i;
                            cmd_addr <= req_whole ? '0 : base_i;
                            left_q   <= req_whole ? CNT_W'(1) : count_i;
                            state    <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready) begin
                        cmd_addr <= cmd_addr + step_q;
                        left_q   <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            if (op_q[1]) begin
                                state <= ST_WAIT;
                            end else begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (!wb_busy) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: pending command holds until taken
    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_kind)));

    // R11: done lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: disabled request finishes at once with no command
    p_dis_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && disabled_i) |=> (done && !cmd_valid));

    // R7: empty range finishes at once with no command
    p_empty_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req_whole && empty_i) |=> (done && !cmd_valid));

    // R8: no completion while write-back is still running
    p_wait_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && wb_busy) |=> !done);

    // R9: pure invalidate completes right after last acceptance
    p_inv_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && left_q == CNT_W'(1) && !op_q[1]) |=> done);

    // R10: whole-cache command carries address zero
    p_whole_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind[1]) |-> (cmd_addr == '0));

endmodule

// File: rtl/dcache_maint_seq.sv
// Module: top of the data cache maintenance sequencer. Connects the
// control register, the range calculator and the sequencer FSM.
// Assumes: cache side follows valid/ready and reports write-back on wb_busy.
module dcache_maint_seq #(
    parameter int AW    = 32,
    parameter int LEN_W = 4,
    parameter int CW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic             req_whole,
    input  logic [AW-1:0]    req_start,
    input  logic [AW-1:0]    req_end,
    input  logic [LEN_W-1:0] cfg_line_len,
    input  logic             ctl_wr_en,
    input  logic [CW-1:0]    ctl_wr_data,
    output logic [CW-1:0]    ctl_rd_data,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [1:0]       cmd_kind,
    output logic [AW-1:0]    cmd_addr,
    input  logic             wb_busy,
    output logic             done
);

    localparam int CNT_W = AW + 2;

    logic [AW-1:0]    base;
    logic [AW-1:0]    step;
    logic [CNT_W-1:0] count;
    logic             empty;
    logic             dis;
    logic             imode;
    logic             mode_set;
    logic             mode_clr;

    dcm_ctl_reg #(.CW(CW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .seq_busy (!req_ready),
        .mode_set (mode_set),
        .mode_clr (mode_clr),
        .wb_busy  (wb_busy),
        .rd_data  (ctl_rd_data),
        .dis_o    (dis),
        .imode_o  (imode)
    );

    dcm_range_calc #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_calc (
        .start_i (req_start),
        .end_i   (req_end),
        .len_i   (cfg_line_len),
        .base_o  (base),
        .step_o  (step),
        .count_o (count),
        .empty_o (empty)
    );

    dcm_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_whole  (req_whole),
        .base_i     (base),
        .step_i     (step),
        .count_i    (count),
        .empty_i    (empty),
        .disabled_i (dis),
        .cmd_ready  (cmd_ready),
        .wb_busy    (wb_busy),
        .req_ready  (req_ready),
        .mode_set   (mode_set),
        .mode_clr   (mode_clr),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .cmd_addr   (cmd_addr),
        .done       (done)
    );

    // R3: an invalidate-kind command under a flush op runs with mode set
    p_flushinv_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_kind[0]) |-> (imode == u_seq.op_q[1]));

    // R1: status bit mirrors the write-back input
    p_wbst_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[8] == wb_busy);

endmodule

// File: tb/dcache_maint_seq_tb.sv
module dcache_maint_seq_tb;

    localparam int AW    = 32;
    localparam int LEN_W = 4;
    localparam int CW    = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = 2'b00;
    logic             req_whole = 1'b0;
    logic [AW-1:0]    req_start = '0;
    logic [AW-1:0]    req_end = '0;
    logic [LEN_W-1:0] cfg_line_len = '0;
    logic             ctl_wr_en = 1'b0;
    logic [CW-1:0]    ctl_wr_data = '0;
    logic [CW-1:0]    ctl_rd_data;
    logic             cmd_valid;
    logic             cmd_ready = 1'b0;
    logic [1:0]       cmd_kind;
    logic [AW-1:0]    cmd_addr;
    logic             wb_busy;
    logic             done;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    int busy_cnt = 0;
    int busyn_cfg = 0;
    logic force_busy = 1'b0;
    logic [3:0] rdy_pat = 4'b1111;

    longint log_addr [64];
    int     log_kind [64];
    int     log_edge [64];
    int     n_cmd = 0;
    int     n_acc = 0;
    int     n_done = 0;
    int     acc_edge = 0;
    int     done_edge = 0;

    dcache_maint_seq #(.AW(AW), .LEN_W(LEN_W), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_whole(req_whole), .req_start(req_start), .req_end(req_end),
        .cfg_line_len(cfg_line_len), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .wb_busy(wb_busy), .done(done)
    );

    always #10 clk = ~clk;

    assign wb_busy = (busy_cnt != 0) || force_busy;

    always @(posedge clk) edge_n <= edge_n + 1;

    // Cache responder: ready pattern and write-back busy window.
    always @(posedge clk) begin
        if (cmd_valid && cmd_ready && (cmd_kind[0] || ctl_rd_data[6]))
            busy_cnt <= busyn_cfg;
        else if (busy_cnt != 0)
            busy_cnt <= busy_cnt - 1;
        #2 cmd_ready = rdy_pat[edge_n % 4];
    end

    // Monitor at falling edge.
    always @(negedge clk) begin
        if (cmd_valid && cmd_ready) begin
            if (n_cmd < 64) begin
                log_addr[n_cmd] = longint'(cmd_addr);
                log_kind[n_cmd] = int'(cmd_kind);
                log_edge[n_cmd] = edge_n + 1;
            end
            n_cmd = n_cmd + 1;
        end
        if (req_valid && req_ready) begin
            acc_edge = edge_n + 1;
            n_acc = n_acc + 1;
        end
        if (done) begin
            done_edge = edge_n;
            n_done = n_done + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_cmd = 0; n_acc = 0; n_done = 0; acc_edge = 0; done_edge = 0;
    endtask

    task automatic issue(input logic [1:0] op, input bit whole, input longint s, input longint e,
                         input bit do_wr, input logic [CW-1:0] wdata);
        @(posedge clk); #2;
        req_valid = 1'b1; req_op = op; req_whole = whole;
        req_start = s[AW-1:0]; req_end = e[AW-1:0];
        ctl_wr_en = do_wr; ctl_wr_data = wdata;
        @(posedge clk); #2;
        req_valid = 1'b0; ctl_wr_en = 1'b0;
    endtask

    task automatic ctl_write(input logic [CW-1:0] wdata);
        @(posedge clk); #2;
        ctl_wr_en = 1'b1; ctl_wr_data = wdata;
        @(posedge clk); #2;
        ctl_wr_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (n_done > 0) break;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    // Compare the logged run against the requirement model.
    task automatic check_run(input logic [1:0] op, input bit whole, input longint s, input longint e,
                             input int len, input bit dis, input string tag);
        longint ls, off, base, n;
        bit skip;
        int exp_done;
        ls   = 64'd16 << len;
        off  = s % ls;
        base = s - off;
        skip = dis || (op == 2'b00) || (!whole && !(s < e));
        n    = skip ? 0 : (whole ? 1 : (e - s + off + ls - 1) / ls);
        chk(n_acc == 1, {tag, " accept count R11"}, n_acc, 1);
        chk(n_cmd == n, {tag, " command count R4"}, n_cmd, n);
        for (int i = 0; i < n && i < 64; i++) begin
            longint ea;
            int ek;
            ea = whole ? 0 : base + i * ls;
            ek = {whole, op == 2'b10};
            chk(log_addr[i] == ea, {tag, " address R4 R5 R10"}, log_addr[i], ea);
            chk(log_kind[i] == ek, {tag, " kind R3"}, log_kind[i], ek);
        end
        if (skip) exp_done = acc_edge;
        else if (op[1]) exp_done = log_edge[n-1] + busyn_cfg + 1;
        else exp_done = log_edge[n-1];
        chk(n_done == 1, {tag, " single done R11"}, n_done, 1);
        chk(done_edge == exp_done, {tag, " done timing R6 R7 R8 R9"}, done_edge, exp_done);
        if (!skip)
            chk(ctl_rd_data[6] == op[1], {tag, " invalidate-mode R2"}, ctl_rd_data[6], op[1]);
    endtask

    task automatic run_case(input logic [1:0] op, input bit whole, input longint s, input longint e,
                            input int len, input int busyn, input logic [3:0] pat,
                            input bit dis, input string tag);
        clear_log();
        cfg_line_len = len[LEN_W-1:0];
        busyn_cfg = busyn;
        rdy_pat = pat;
        issue(op, whole, s, e, 1'b0, '0);
        wait_done();
        check_run(op, whole, s, e, len, dis, tag);
    endtask

    task automatic t_reset();
        chk(ctl_rd_data == '0, "reset ctl R1", ctl_rd_data, 0);
        chk(req_ready == 1'b1, "reset ready R11", req_ready, 1);
        chk(cmd_valid == 1'b0, "reset cmd_valid R11", cmd_valid, 0);
        chk(done == 1'b0, "reset done R11", done, 0);
    endtask

    task automatic t_ctl_reg();
        ctl_write(32'h0000_0141);
        @(negedge clk); #1;
        chk(ctl_rd_data == 32'h41, "ctl write R1", ctl_rd_data, 32'h41);
        force_busy = 1'b1;
        @(negedge clk); #1;
        chk(ctl_rd_data == 32'h141, "wb status bit8 R1", ctl_rd_data, 32'h141);
        force_busy = 1'b0;
        ctl_write(32'h0);
        @(negedge clk); #1;
        chk(ctl_rd_data == 32'h0, "ctl clear R1", ctl_rd_data, 0);
    endtask

    task automatic t_ranges();
        run_case(2'b11, 1'b0, 64'h1003, 64'h1025, 0, 3, 4'b1111, 1'b0, "flushinv range R3 R4 R8");
        run_case(2'b10, 1'b0, 64'h2040, 64'h2100, 2, 5, 4'b0101, 1'b0, "flush range R5 R8");
        run_case(2'b10, 1'b0, 64'h2201, 64'h2202, 3, 0, 4'b0011, 1'b0, "flush one byte R4 R8");
    endtask

    task automatic t_pure_inv();
        force_busy = 1'b1;
        run_case(2'b01, 1'b0, 64'h301F, 64'h3021, 1, 0, 4'b1111, 1'b0, "pure inv R2 R9");
        force_busy = 1'b0;
    endtask

    task automatic t_whole();
        run_case(2'b10, 1'b1, 64'h0, 64'h0, 0, 4, 4'b0110, 1'b0, "whole flush R10");
        run_case(2'b01, 1'b1, 64'h55, 64'h10, 0, 2, 4'b1111, 1'b0, "whole inv R10");
        run_case(2'b11, 1'b1, 64'h0, 64'h0, 0, 2, 4'b1111, 1'b0, "whole flushinv R10");
    endtask

    task automatic t_empty();
        run_case(2'b10, 1'b0, 64'h4000, 64'h4000, 0, 2, 4'b1111, 1'b0, "start eq end R7");
        run_case(2'b11, 1'b0, 64'h4100, 64'h4000, 0, 2, 4'b1111, 1'b0, "start above end R7");
        run_case(2'b00, 1'b0, 64'h4000, 64'h4100, 0, 2, 4'b1111, 1'b0, "null op R7");
    endtask

    task automatic t_disabled();
        ctl_write(32'h1);
        run_case(2'b11, 1'b0, 64'h5000, 64'h5100, 0, 2, 4'b1111, 1'b1, "disabled R6");
        run_case(2'b10, 1'b1, 64'h0, 64'h0, 0, 2, 4'b1111, 1'b1, "disabled whole R6");
        ctl_write(32'h0);
    endtask

    task automatic t_busy_refuse();
        bit saw_ready;
        saw_ready = 1'b0;
        clear_log();
        cfg_line_len = '0;
        busyn_cfg = 0;
        rdy_pat = 4'b0001;
        issue(2'b01, 1'b0, 64'h6000, 64'h6080, 1'b0, '0);
        @(posedge clk); #2;
        req_valid = 1'b1; req_op = 2'b10; req_whole = 1'b1;
        ctl_wr_en = 1'b1; ctl_wr_data = 32'h40;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (req_ready) saw_ready = 1'b1;
        end
        @(posedge clk); #2;
        req_valid = 1'b0; ctl_wr_en = 1'b0;
        chk(!saw_ready, "ready low while busy R11", saw_ready, 0);
        req_op = 2'b01; req_whole = 1'b0;
        wait_done();
        check_run(2'b01, 1'b0, 64'h6000, 64'h6080, 0, 1'b0, "busy refuse R11 R2");
    endtask

    task automatic t_same_cycle();
        clear_log();
        cfg_line_len = '0; busyn_cfg = 0; rdy_pat = 4'b1111;
        issue(2'b01, 1'b0, 64'h7000, 64'h7020, 1'b1, 32'h40);
        wait_done();
        check_run(2'b01, 1'b0, 64'h7000, 64'h7020, 0, 1'b0, "write+accept mode R2");
        clear_log();
        busyn_cfg = 2;
        issue(2'b10, 1'b0, 64'h7100, 64'h7120, 1'b1, 32'h1);
        wait_done();
        check_run(2'b10, 1'b0, 64'h7100, 64'h7120, 0, 1'b0, "write-disable+accept R6");
        chk(ctl_rd_data[0] == 1'b1, "disable bit after same-cycle write R6", ctl_rd_data[0], 1);
        run_case(2'b10, 1'b0, 64'h7200, 64'h7220, 0, 2, 4'b1111, 1'b1, "after same-cycle disable R6");
        ctl_write(32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_ctl_reg();
        t_ranges();
        t_pure_inv();
        t_whole();
        t_empty();
        t_disabled();
        t_busy_refuse();
        t_same_cycle();
        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R11: actual %0d cycles expected completion", 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule